// File: doc/BRIEF.md
# Synchronous Memory Read Output Stage

This block is the read side of a synchronous static memory. An address strobe, qualified by three chip enables, captures an address, a write command and write data on a rising clock edge. A small behavioural array sits behind the captured address. Its read data leaves the block in one of two ways, chosen by a static mode pin. In flow-through mode the data follows the address register directly. In pipelined mode one more register is added, so the data arrives an edge later. Writes go into the array on the same edge that captures the command.

A clock-enable input freezes every register and blocks writes. A tristate-enable output tells the pad ring when to drive the data bus. It combines the registered read-valid state, an asynchronous active-low output enable and a write that is being captured in the current cycle. The read path uses a fixed latency, so the data output has no ready signal and cannot be stalled from downstream. The only way to hold it is the clock enable, which freezes both stages. A pipelined read followed by a write needs two idle cycles in between, so that the write does not suppress read data that is still due.

Top module: `sync_read_port`

## Requirements
- R1: While reset is asserted, and until the first access after it, `rd_valid` and `drive_en` are 0.
- R2: With `pipe_mode`=0, a read captured on edge E shows `rd_valid`=1 and the addressed word on `rdata` after E.
- R3: With `pipe_mode`=1, a read captured on edge E shows `rd_valid`=0 after E, and `rd_valid`=1 with the addressed word after edge E+1.
- R4: An access starts only when `strobe`=1, `ce0_n`=0, `ce1_n`=0 and `ce2`=1 on the edge. A strobe with any enable inactive starts nothing.
- R5: An enabled edge that starts no read clears the first stage. In flow-through mode `rd_valid` falls after that single edge; in pipelined mode it falls one edge later.
- R6: While `clk_en`=0, the registers hold their state and writes are ignored. `rd_valid` and `rdata` stay unchanged, and the array contents are kept.
- R7: A started access is a write when `wr_all`=1 or `byte_en` is nonzero. `wr_all`=1 writes all bytes. Otherwise bit i of `byte_en` writes `wdata[8i+7:8i]`, and unselected bytes keep their contents.
- R8: `drive_en` is 1 exactly when `rd_valid`=1, `oe_n`=0 and no write is being captured. It follows `oe_n` within the same cycle, without waiting for a clock edge.
- R9: During a cycle in which `clk_en`=1 and a write is started, `drive_en` is 0, even if read data is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; 0 holds all registers |
| pipe_mode | input | 1 | Static mode: 1 pipelined, 0 flow-through |
| strobe | input | 1 | Address strobe, active high |
| ce0_n | input | 1 | Master chip enable, active low |
| ce1_n | input | 1 | Second chip enable, active low |
| ce2 | input | 1 | Third chip enable, active high |
| wr_all | input | 1 | Write every byte |
| byte_en | input | NB | Per-byte write selects |
| addr | input | log2(DEPTH) | Word address |
| wdata | input | 8*NB | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 8*NB | Read data, zero when not valid |
| rd_valid | output | 1 | Read data present on `rdata` |
| drive_en | output | 1 | Tristate enable for the data pads |

## Verification
Read data is due right after the capturing edge in flow-through mode and one edge later in pipelined mode. `drive_en` depends on the inputs of the current cycle. The bench drives all inputs just after the falling edge and waits one nanosecond. It then compares the outputs with a reference model that was advanced at the preceding rising edges. That model counts one stage for flow-through and two for pipelined, so every result is checked in the cycle it is due, and `oe_n` changes are observed inside a cycle.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic logic chip_selected(input logic ce0_n, input logic ce1_n, input logic ce2);
    return !ce0_n && !ce1_n && ce2;
  endfunction

endpackage

// File: rtl/srp_addr_stage.sv
module srp_addr_stage
  import srp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NB    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = 8 * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          strobe,
  input  logic          ce0_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          wr_all,
  input  logic [NB-1:0] byte_en,
  input  logic [AW-1:0] addr,
  output logic          st1_rd,
  output logic [AW-1:0] addr_q,
  output logic          wr_cap,
  output logic [NB-1:0] lane_we
);

  acc_e kind_now;
  acc_e kind_q;
  logic sel_now;
  logic is_write;

  assign sel_now  = strobe && chip_selected(ce0_n, ce1_n, ce2);
  assign is_write = wr_all || (|byte_en);

  always_comb begin
    if (!sel_now)      kind_now = ACC_NONE;
    else if (is_write) kind_now = ACC_WRITE;
    else               kind_now = ACC_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= ACC_NONE;
      addr_q <= '0;
    end else if (clk_en) begin
      kind_q <= kind_now;
      if (sel_now) addr_q <= addr;
    end
  end

  assign st1_rd  = (kind_q == ACC_READ);
  assign wr_cap  = clk_en && (kind_now == ACC_WRITE);
  assign lane_we = wr_cap ? (wr_all ? {NB{1'b1}} : byte_en) : '0;

endmodule

// File: rtl/srp_mem_array.sv
module srp_mem_array #(
  parameter int DEPTH = 16,
  parameter int NB    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = 8 * NB
) (
  input  logic          clk,
  input  logic [NB-1:0] lane_we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) cells[waddr] <= wdata[8*g +: 8];
    end

    assign rdata[8*g +: 8] = cells[raddr];
  end

endmodule

// File: rtl/srp_out_stage.sv
module srp_out_stage #(
  parameter int NB  = 4,
  localparam int DW = 8 * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          pipe_mode,
  input  logic          st1_rd,
  input  logic [DW-1:0] arr_data,
  input  logic          oe_n,
  input  logic          wr_cap,
  output logic          rd_valid,
  output logic [DW-1:0] rdata,
  output logic          drive_en
);

  logic          st2_rd;
  logic [DW-1:0] data_q;
  logic [DW-1:0] sel_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st2_rd <= 1'b0;
      data_q <= '0;
    end else if (clk_en) begin
      st2_rd <= st1_rd;
      data_q <= arr_data;
    end
  end

  assign rd_valid = pipe_mode ? st2_rd : st1_rd;
  assign sel_data = pipe_mode ? data_q : arr_data;
  assign rdata    = rd_valid ? sel_data : '0;
  assign drive_en = rd_valid && !oe_n && !wr_cap;

endmodule

// File: rtl/sync_read_port.sv
module sync_read_port #(
  parameter int DEPTH = 16,
  parameter int NB    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int DW   = 8 * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          pipe_mode,
  input  logic          strobe,
  input  logic          ce0_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          wr_all,
  input  logic [NB-1:0] byte_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rd_valid,
  output logic          drive_en
);

  logic          st1_rd;
  logic [AW-1:0] addr_q;
  logic          wr_cap;
  logic [NB-1:0] lane_we;
  logic [DW-1:0] arr_data;

  srp_addr_stage #(.DEPTH(DEPTH), .NB(NB)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .strobe  (strobe),
    .ce0_n   (ce0_n),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .wr_all  (wr_all),
    .byte_en (byte_en),
    .addr    (addr),
    .st1_rd  (st1_rd),
    .addr_q  (addr_q),
    .wr_cap  (wr_cap),
    .lane_we (lane_we)
  );

  srp_mem_array #(.DEPTH(DEPTH), .NB(NB)) u_array (
    .clk     (clk),
    .lane_we (lane_we),
    .waddr   (addr),
    .wdata   (wdata),
    .raddr   (addr_q),
    .rdata   (arr_data)
  );

  srp_out_stage #(.NB(NB)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .pipe_mode (pipe_mode),
    .st1_rd    (st1_rd),
    .arr_data  (arr_data),
    .oe_n      (oe_n),
    .wr_cap    (wr_cap),
    .rd_valid  (rd_valid),
    .rdata     (rdata),
    .drive_en  (drive_en)
  );

endmodule

// File: rtl/sync_read_port_chk.sv
module sync_read_port_chk #(
  parameter int NB  = 4,
  localparam int DW = 8 * NB
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          pipe_mode,
  input logic          strobe,
  input logic          ce0_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          wr_all,
  input logic [NB-1:0] byte_en,
  input logic          oe_n,
  input logic [DW-1:0] rdata,
  input logic          rd_valid,
  input logic          drive_en,
  input logic          st1_rd
);

  logic sel_in;
  logic wr_in;
  assign sel_in = strobe && !ce0_n && !ce1_n && ce2;
  assign wr_in  = wr_all || (|byte_en);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!rd_valid && !drive_en));

  assert_pipe_second_stage_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> (!pipe_mode || (rd_valid == $past(st1_rd))));

  assert_deselect_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && strobe && !sel_in) |=> (pipe_mode || !rd_valid));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ((pipe_mode != $past(pipe_mode)) || ($stable(rd_valid) && $stable(rdata))));

  assert_drive_needs_valid_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (rd_valid && !oe_n));

  assert_write_mutes_pads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sel_in && wr_in) |-> !drive_en);

endmodule

bind sync_read_port sync_read_port_chk #(.NB(NB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en    (clk_en),
  .pipe_mode (pipe_mode),
  .strobe    (strobe),
  .ce0_n     (ce0_n),
  .ce1_n     (ce1_n),
  .ce2       (ce2),
  .wr_all    (wr_all),
  .byte_en   (byte_en),
  .oe_n      (oe_n),
  .rdata     (rdata),
  .rd_valid  (rd_valid),
  .drive_en  (drive_en),
  .st1_rd    (st1_rd)
);

// File: tb/test_sync_read_port.sv
`timescale 1ns/1ps
module test_sync_read_port;
  localparam int DEPTH = 16;
  localparam int NB    = 4;
  localparam int AW    = 4;
  localparam int DW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clk_en = 1'b1, pipe_mode = 1'b0;
  logic strobe = 1'b0, ce0_n = 1'b0, ce1_n = 1'b0, ce2 = 1'b1;
  logic wr_all = 1'b0, oe_n = 1'b0;
  logic [NB-1:0] byte_en = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rd_valid, drive_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  bit            m_s1 = 1'b0, m_s2 = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_d2 = '0;

  always #4 clk = ~clk;

  sync_read_port #(.DEPTH(DEPTH), .NB(NB)) i_sync_read_port (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pipe_mode(pipe_mode),
    .strobe(strobe), .ce0_n(ce0_n), .ce1_n(ce1_n), .ce2(ce2),
    .wr_all(wr_all), .byte_en(byte_en), .addr(addr), .wdata(wdata),
    .oe_n(oe_n), .rdata(rdata), .rd_valid(rd_valid), .drive_en(drive_en)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return 32'h9E37_79B9 * (a + 1);
  endfunction

  function automatic bit sel_f();
    return strobe && !ce0_n && !ce1_n && ce2;
  endfunction

  function automatic bit wr_f();
    return wr_all || (byte_en != '0);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit ev;
    bit ed;
    ev = pipe_mode ? m_s2 : m_s1;
    chk(rd_valid == ev, "R5 valid", DW'(rd_valid), DW'(ev));
    if (ev) chk(rdata == (pipe_mode ? m_d2 : m_mem[m_addr]), pipe_mode ? "R3 data" : "R2 data",
                rdata, pipe_mode ? m_d2 : m_mem[m_addr]);
    ed = ev && !oe_n && !(clk_en && sel_f() && wr_f());
    chk(drive_en == ed, "R8 drive", DW'(drive_en), DW'(ed));
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    if (!rst_n) begin
      m_s1 = 1'b0;
      m_s2 = 1'b0;
    end else if (clk_en) begin
      m_s2 = m_s1;
      m_d2 = m_mem[m_addr];
      if (sel_f()) begin
        m_addr = addr;
        if (wr_f())
          for (int b = 0; b < NB; b++)
            if (wr_all || byte_en[b]) m_mem[addr][8*b +: 8] = wdata[8*b +: 8];
      end
      m_s1 = sel_f() && !wr_f();
    end
    @(negedge clk);
  endtask

  task automatic idle();
    strobe = 1'b0; wr_all = 1'b0; byte_en = '0;
  endtask

  task automatic rd(input int a);
    strobe = 1'b1; wr_all = 1'b0; byte_en = '0; addr = AW'(a);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input logic all, input logic [NB-1:0] be);
    strobe = 1'b1; wr_all = all; byte_en = be; addr = AW'(a); wdata = d;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // R1: reset with a read strobe present
    rd(1);
    step(); step(); step();
    chk(!rd_valid && !drive_en, "R1", DW'({rd_valid, drive_en}), '0);
    rst_n = 1'b1;
    idle();
    step();
    chk(!rd_valid, "R1", DW'(rd_valid), '0);

    for (int a = 0; a < DEPTH; a++) begin
      wr(a, pat(a), 1'b1, '0);
      step();
    end
    idle(); step();

    // R2: flow-through, data right after capturing edge
    rd(5); step();
    chk(rd_valid && rdata == pat(5), "R2", rdata, pat(5));
    idle(); step();
    chk(!rd_valid, "R5", DW'(rd_valid), '0);

    // R3: pipelined, one extra edge
    pipe_mode = 1'b1; step(); step();
    rd(6); step();
    chk(!rd_valid, "R3", DW'(rd_valid), '0);
    idle(); step();
    chk(rd_valid && rdata == pat(6), "R3", rdata, pat(6));
    step();
    chk(!rd_valid, "R5", DW'(rd_valid), '0);

    // R4: each inactive enable blocks the access
    pipe_mode = 1'b0; step();
    rd(2); ce2 = 1'b0; step();
    chk(!rd_valid, "R4", DW'(rd_valid), '0);
    ce2 = 1'b1; ce1_n = 1'b1; step();
    chk(!rd_valid, "R4", DW'(rd_valid), '0);
    ce1_n = 1'b0; ce0_n = 1'b1; step();
    chk(!rd_valid, "R4", DW'(rd_valid), '0);
    ce0_n = 1'b0; step();
    chk(rd_valid && rdata == pat(2), "R4", rdata, pat(2));

    // R6: hold ignores a write
    rd(7); step();
    clk_en = 1'b0;
    wr(7, 32'hDEAD_BEEF, 1'b1, '0); step(); step();
    chk(rd_valid && rdata == pat(7), "R6", rdata, pat(7));
    clk_en = 1'b1;
    rd(7); step();
    chk(rdata == pat(7), "R6", rdata, pat(7));

    // R7: byte lanes 0 and 2 only
    wr(9, 32'h1122_3344, 1'b0, 4'b0101); step();
    rd(9); step();
    chk(rdata == ((pat(9) & 32'hFF00_FF00) | 32'h0022_0044), "R7", rdata,
        (pat(9) & 32'hFF00_FF00) | 32'h0022_0044);

    // R8: asynchronous output enable inside one cycle
    rd(3); step();
    idle(); oe_n = 1'b1; #1;
    chk(!drive_en, "R8", DW'(drive_en), '0);
    oe_n = 1'b0; #1;
    chk(drive_en, "R8", DW'(drive_en), 32'd1);
    step();

    // R9: write captured while pipelined data is due
    pipe_mode = 1'b1; step(); step();
    rd(4); step();
    idle(); step();
    wr(10, 32'h0BAD_F00D, 1'b1, '0); #1;
    chk(rd_valid && !drive_en, "R9", DW'({rd_valid, drive_en}), 32'd2);
    step();
    idle(); step(); step();

    for (int i = 0; i < 3000; i++) begin
      if (i % 300 == 0) pipe_mode = ~pipe_mode;
      strobe  = ($urandom_range(0, 9) < 7);
      ce0_n   = ($urandom_range(0, 9) == 0);
      ce1_n   = ($urandom_range(0, 9) == 0);
      ce2     = ($urandom_range(0, 9) != 0);
      wr_all  = ($urandom_range(0, 9) == 0);
      byte_en = ($urandom_range(0, 3) == 0) ? NB'($urandom) : '0;
      addr    = AW'($urandom);
      wdata   = $urandom;
      clk_en  = ($urandom_range(0, 9) != 0);
      oe_n    = ($urandom_range(0, 9) < 2);
      step();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule